// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Low Recovery Controller

This block watches the clock and data lines of a two-wire open-drain bus and finds the case where the bus has hung low. A timer runs while at least one line is sampled low. Any cycle in which both lines are sampled high clears it. When the timer reaches the configured timeout, the block raises a disconnect flag. Forwarding logic next to the block uses this flag to stop passing bus states through. The block then takes over the bus with its own pull-down outputs for a bounded recovery sequence.

The recovery sequence clocks SCL up to a fixed maximum number of times. This lets a slave that is part-way through a byte shift out its remaining bits and let go of SDA. Clocking stops early once both lines read high at the end of a high phase. The block then generates a STOP condition and checks the bus. If the bus is free, it reports done. If not, it reports fail, and the stuck timer starts again from zero. A clock-frequency parameter sets both the timeout length in cycles and the half-period of the recovery clock.

Top module: `i2c_stuck_recovery`

## Requirements
- R1: `disconnect_o` rises on the edge that takes the TIMEOUT-th consecutive synchronised sample with SCL or SDA low. TIMEOUT = (CLK_FREQ_HZ/1000)*STUCK_MS. Line inputs pass through a SYNC_STAGES-deep synchroniser, so this edge is SYNC_STAGES+TIMEOUT edges after a line first goes low.
- R2: One synchronised sample with both lines high clears the timer. Low stretches of TIMEOUT-1 samples, separated by one high sample, never raise `disconnect_o`. Low periods that alternate between the two lines, with no sample where both are high, still count as one continuous stuck period.
- R3: While `disconnect_o` is low, both `scl_drive_o` and `sda_drive_o` are 0 (pull-downs off).
- R4: A recovery pulse drives `scl_drive_o`=1 for HALF cycles, then 0 for HALF cycles. HALF = CLK_FREQ_HZ/(2*SCL_FREQ_HZ). At most MAX_PULSES pulses are issued per recovery.
- R5: At the end of each high half-period, if both synchronised lines read high, clocking stops. The number of pulses then equals the number of SCL rises the slave needed.
- R6: The STOP is built in four HALF-cycle phases, in this order:
  1. SCL low only.
  2. SCL and SDA low.
  3. SCL released, SDA low.
  4. Both released.

  `sda_drive_o` rises only while SCL has already been driven low. It falls only while SCL is released. It is high for exactly 2*HALF cycles.
- R7: `disconnect_o` stays high for exactly (2*P+4)*HALF cycles, where P is the number of pulses issued.
- R8: At the end of recovery, `done_o`=1 if both lines read high, else `fail_o`=1. The two are never both high. Both hold until the next detection, which clears them.
- R9: After a failed recovery, the timer restarts from zero. With the bus still stuck, `disconnect_o` is low for exactly TIMEOUT cycles before it rises again.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_drive_o | output | 1 | 1 = pull SCL low |
| sda_drive_o | output | 1 | 1 = pull SDA low |
| disconnect_o | output | 1 | High from detection until recovery ends |
| done_o | output | 1 | Last recovery left the bus free |
| fail_o | output | 1 | Last recovery left the bus stuck |

## Verification
The bench models a slave that holds SDA low until it has seen k SCL rises, with k swept from 1 to 16. Each run must yield exactly k pulses and a window of (2k+4)*HALF cycles, which separates the early-exit check from the pulse bound. A slave that never lets go, and a separate permanent SCL hold, drive the 16-pulse limit and the fail path. They also measure the restart gap after a failure. Two more patterns test the timer:
- Low stretches one sample short of the timeout, with a single high sample between them, must never trigger.
- Lows that alternate between SDA and SCL, with no sample where both are high, must still trigger.

Together these show that only a both-high sample clears the timer.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STP_PRE,
    ST_STP_SDA,
    ST_STP_SCL,
    ST_STP_REL
  } rcv_state_e;
endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // idle bus reads high
  if (STAGES <= 1) begin : g_single
    logic [WIDTH-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) r_q <= '1;
      else         r_q <= d_i;
    assign q_o = r_q;
  end else begin : g_chain
    localparam int unsigned CHW = STAGES * WIDTH;
    logic [CHW-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[CHW-WIDTH-1:0], d_i};
    assign q_o = chain_q[CHW-1 -: WIDTH];
  end
endmodule

// File: rtl/i2c_rcv_stuck_timer.sv
module i2c_rcv_stuck_timer #(
  parameter int unsigned TIMEOUT_CYC = 1850000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic stuck_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          any_low;

  assign any_low = !scl_i || !sda_i;
  assign stuck_o = arm_i && any_low && (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i || !any_low) cnt_q <= '0;
    else if (stuck_o)            cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/i2c_rcv_half_tick.sv
module i2c_rcv_half_tick #(
  parameter int unsigned HALF_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned HW = $clog2(HALF_CYC + 1);

  logic [HW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == HW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/i2c_rcv_seq.sv
module i2c_rcv_seq
  import i2c_rcv_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_o,
  output logic sda_drive_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);

  rcv_state_e    state_q;
  logic [PW-1:0] pulse_q;
  logic          done_q, fail_q;
  logic          bus_free;

  assign bus_free = scl_i && sda_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CLK_LO;
          pulse_q <= '0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
        end
        ST_CLK_LO: if (tick_i) begin
          state_q <= ST_CLK_HI;
          pulse_q <= pulse_q + 1'b1;
        end
        ST_CLK_HI: if (tick_i) begin
          // early exit once the slave has let go
          if (bus_free || pulse_q == PW'(MAX_PULSES)) state_q <= ST_STP_PRE;
          else                                        state_q <= ST_CLK_LO;
        end
        ST_STP_PRE: if (tick_i) state_q <= ST_STP_SDA;
        ST_STP_SDA: if (tick_i) state_q <= ST_STP_SCL;
        ST_STP_SCL: if (tick_i) state_q <= ST_STP_REL;
        ST_STP_REL: if (tick_i) begin
          state_q <= ST_IDLE;
          done_q  <= bus_free;
          fail_q  <= !bus_free;
        end
        default: state_q <= ST_IDLE;
      endcase
    end

  always_comb begin
    scl_drive_o = 1'b0;
    sda_drive_o = 1'b0;
    unique case (state_q)
      ST_CLK_LO:  scl_drive_o = 1'b1;
      ST_STP_PRE: scl_drive_o = 1'b1;
      ST_STP_SDA: begin scl_drive_o = 1'b1; sda_drive_o = 1'b1; end
      ST_STP_SCL: sda_drive_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/i2c_stuck_recovery.sv
module i2c_stuck_recovery #(
  parameter int unsigned CLK_FREQ_HZ = 50000000,
  parameter int unsigned STUCK_MS    = 37,
  parameter int unsigned SCL_FREQ_HZ = 100000,
  parameter int unsigned MAX_PULSES  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_o,
  output logic sda_drive_o,
  output logic disconnect_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned TIMEOUT_CYC = (CLK_FREQ_HZ / 1000) * STUCK_MS;
  localparam int unsigned HALF_CYC    = CLK_FREQ_HZ / (2 * SCL_FREQ_HZ);

  logic scl_s, sda_s;
  logic busy, stuck, tick;

  i2c_rcv_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_rcv_stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (!busy),
    .scl_i  (scl_s),
    .sda_i  (sda_s),
    .stuck_o(stuck)
  );

  i2c_rcv_half_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .tick_o(tick)
  );

  i2c_rcv_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (stuck),
    .tick_i     (tick),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_drive_o(scl_drive_o),
    .sda_drive_o(sda_drive_o),
    .busy_o     (busy),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  assign disconnect_o = busy;
endmodule

// File: rtl/i2c_stuck_recovery_chk.sv
module i2c_stuck_recovery_chk #(
  parameter int unsigned MAX_PULSES = 16,
  parameter int unsigned HALF_CYC   = 250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_drive_o,
  input logic sda_drive_o,
  input logic disconnect_o,
  input logic done_o,
  input logic fail_o
);
  logic [15:0] asserts_q;
  logic [31:0] win_q;
  logic        scl_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      asserts_q  <= '0;
      win_q      <= '0;
      scl_prev_q <= 1'b0;
    end else begin
      scl_prev_q <= scl_drive_o;
      if (!disconnect_o) begin
        asserts_q <= '0;
        win_q     <= '0;
      end else begin
        win_q <= win_q + 1'b1;
        if (scl_drive_o && !scl_prev_q) asserts_q <= asserts_q + 1'b1;
      end
    end

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disconnect_o |-> (!scl_drive_o && !sda_drive_o));

  p_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_o) |-> (scl_drive_o && $past(scl_drive_o)));

  p_stop_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_drive_o) |-> (!scl_drive_o && !$past(scl_drive_o)));

  p_status_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  p_status_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disconnect_o) |-> (!done_o && !fail_o));

  p_pulse_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(asserts_q) <= MAX_PULSES + 1);

  p_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= (2 * MAX_PULSES + 4) * HALF_CYC);
endmodule

bind i2c_stuck_recovery i2c_stuck_recovery_chk #(
  .MAX_PULSES(MAX_PULSES),
  .HALF_CYC  (HALF_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_drive_o (scl_drive_o),
  .sda_drive_o (sda_drive_o),
  .disconnect_o(disconnect_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/i2c_stuck_recovery_test.sv
`timescale 1ns/1ps
module i2c_stuck_recovery_test;
  localparam int CLK_HZ = 40000;
  localparam int MS     = 37;
  localparam int SCL_HZ = 4000;
  localparam int MAXP   = 16;
  localparam int SYNC   = 2;
  localparam int T      = (CLK_HZ / 1000) * MS;
  localparam int H      = CLK_HZ / (2 * SCL_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drive, sda_drive, disconnect, done, fail;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic slv_hold = 1'b0;
  logic slv_prev = 1'b1;
  int   slv_need = 0, slv_rises = 0;
  int   checks = 0, errors = 0;
  logic scl_line, sda_line;

  always #2 clk = ~clk;

  assign scl_line = !(scl_drive || ext_scl_low);
  assign sda_line = !(sda_drive || ext_sda_low || slv_hold);

  i2c_stuck_recovery #(
    .CLK_FREQ_HZ(CLK_HZ), .STUCK_MS(MS), .SCL_FREQ_HZ(SCL_HZ),
    .MAX_PULSES(MAXP), .SYNC_STAGES(SYNC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_o(scl_drive), .sda_drive_o(sda_drive),
    .disconnect_o(disconnect), .done_o(done), .fail_o(fail)
  );

  // slave holding SDA until it has seen slv_need SCL rises (0 = never)
  always @(negedge clk) begin
    slv_prev <= scl_line;
    if (slv_hold && scl_line && !slv_prev) begin
      slv_rises <= slv_rises + 1;
      if (slv_need != 0 && slv_rises + 1 == slv_need) slv_hold <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_detect(output int n);
    n = 0;
    while (!disconnect && n < 4 * T) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int len, output int pulses, output int sda_len, output int bad_order);
    logic p_scl, p_sda;
    int asserts;
    len = 0; asserts = 0; sda_len = 0; bad_order = 0;
    p_scl = 1'b0; p_sda = 1'b0;
    while (disconnect && len < 8 * (2 * MAXP + 4) * H) begin
      len++;
      if (scl_drive && !p_scl) asserts++;
      if (sda_drive) sda_len++;
      if (sda_drive && !p_sda && !(scl_drive && p_scl)) bad_order++;
      if (!sda_drive && p_sda && (scl_drive || p_scl)) bad_order++;
      p_scl = scl_drive; p_sda = sda_drive;
      @(negedge clk);
    end
    pulses = asserts - 1;
  endtask

  initial begin
    int n, len, p, sl, bad, seen;
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {29'd0, scl_drive, sda_drive, disconnect} + done + fail, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5/R7: sweep slave release point
    for (int k = 1; k <= MAXP; k++) begin
      slv_need = k; slv_rises = 0; slv_hold = 1'b1;
      n = 0; seen = 0;
      while (!disconnect && n < 4 * T) begin
        n++;
        if (n == T / 2 && (scl_drive || sda_drive)) seen = 1;
        @(negedge clk);
      end
      if (k == 1) chk("R3", "drive while idle", seen, 0);
      chk("R1", "detect samples", n, T + SYNC);
      measure(len, p, sl, bad);
      chk("R5", "pulse count", p, k);
      chk("R7", "window length", len, (2 * k + 4) * H);
      chk("R6", "sda low length", sl, 2 * H);
      chk("R6", "stop ordering", bad, 0);
      chk("R8", "done", done, 1);
      chk("R8", "fail", fail, 0);
      repeat (4) @(negedge clk);
    end

    // R4/R9: slave never releases SDA
    slv_need = 0; slv_rises = 0; slv_hold = 1'b1;
    wait_detect(n);
    chk("R1", "detect samples sda hold", n, T + SYNC);
    measure(len, p, sl, bad);
    chk("R4", "pulse bound", p, MAXP);
    chk("R7", "window at bound", len, (2 * MAXP + 4) * H);
    chk("R8", "fail set", fail, 1);
    chk("R8", "done clear", done, 0);
    wait_detect(n);
    chk("R9", "restart gap", n, T);
    chk("R8", "fail cleared on detect", fail, 0);
    slv_hold = 1'b0;
    measure(len, p, sl, bad);
    chk("R5", "pulse after release", p, 1);
    chk("R8", "done after release", done, 1);
    repeat (4) @(negedge clk);

    // R4/R9: SCL held low by another device
    ext_scl_low = 1'b1;
    wait_detect(n);
    chk("R1", "detect samples scl hold", n, T + SYNC);
    measure(len, p, sl, bad);
    chk("R4", "pulse bound scl", p, MAXP);
    chk("R8", "fail scl", fail, 1);
    wait_detect(n);
    chk("R9", "restart gap scl", n, T);
    ext_scl_low = 1'b0;
    measure(len, p, sl, bad);
    chk("R8", "done scl freed", done, 1);
    repeat (4) @(negedge clk);

    // R2: near-timeout lows split by one high sample
    seen = 0;
    for (int r = 0; r < 3; r++) begin
      ext_sda_low = 1'b1;
      repeat (T - 1) begin @(negedge clk); if (disconnect) seen++; end
      ext_sda_low = 1'b0;
      @(negedge clk); if (disconnect) seen++;
    end
    repeat (SYNC + 4) begin @(negedge clk); if (disconnect) seen++; end
    chk("R2", "no trigger on split lows", seen, 0);

    // R2: alternating lows, never both high
    ext_sda_low = 1'b1; n = 0;
    while (!disconnect && n < 4 * T) begin
      n++;
      if (n == 700) begin ext_sda_low = 1'b0; ext_scl_low = 1'b1; end
      @(negedge clk);
    end
    chk("R2", "alternating lows detect", n, T + SYNC);
    ext_scl_low = 1'b0;
    measure(len, p, sl, bad);
    chk("R5", "pulse after alternating", p, 1);
    chk("R8", "done alternating", done, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: got %0d cycles expected fewer", 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule